// File: doc/BRIEF.md
# Per-Timeslot Test Pattern Inserter and Checker

This block sits in the byte path of a framed serial link that carries a fixed number of timeslots per frame. For each byte it is given the timeslot index, the transmit byte and the receive byte, together with two per-timeslot enable vectors from the control block. One enable vector marks the transmit timeslots that should carry a generated test pattern. The other marks the receive timeslots that are checked against a pattern, or replaced by one.

A global select input sets the kind of pattern. With the select low, the block runs a pseudo-random test. Marked transmit timeslots carry a 2^15-1 sequence, and marked receive timeslots feed a self-synchronising checker whose bit errors are counted. With the select high, a repeating eight-byte milliwatt tone is sent in the marked transmit timeslots and written over the marked receive timeslots. A second input chooses the mu-law or the A-law form of that tone.

The generator, the checker and the two tone phase counters move on only when a marked timeslot goes by. A single continuous sequence is therefore spread across whatever set of channels is chosen.

The error checker is built around a small state machine with three states:
- `CHK_IDLE`: tone mode is active.
- `CHK_FILL`: the checker register is still filling.
- `CHK_LOCK`: the checker register holds 15 received bits, and every later bit is compared.

Its transitions are:
- idle to fill: the select returns low.
- fill to lock: a checked byte brings the fill count to 15.
- fill to idle, or lock to idle: the select goes high.

Top module: `ts_pattern_tester`

## Requirements
- R1: After reset, tx_byte_out, rx_byte_out and out_valid are 0, and err_count is 0.
- R2: The outputs are registered. One cycle after a cycle with byte_stb high, out_valid is 1 and the outputs reflect that byte; out_valid is 0 in every other cycle. A transmit byte whose timeslot bit tx_test_en[ts_idx] is 0 passes through unchanged. A receive byte passes through unchanged unless R9 replaces it.
- R3: With pat_sel=0, a timeslot whose bit tx_test_en[ts_idx] is 1 sends the next 8 bits of the x^15+x^14+1 generator, MSB first. The generator is seeded all ones at reset. Each new bit is s[14] xor s[13], and it is shifted into s[0]. The generator advances only on such selected bytes.
- R4: With pat_sel=0, a timeslot whose bit rx_test_en[ts_idx] is 1 feeds its byte, MSB first, to a self-synchronising checker. The first 15 checked bits after reset, or after a return from pat_sel=1, are never errors. After that, each bit that differs from the xor of the bits 15 and 14 positions earlier adds one to err_count. A correct stream from any starting state therefore gives no errors, and one flipped bit gives exactly 3.
- R5: With pat_sel=0, selected receive bytes are passed to rx_byte_out unchanged.
- R6: err_count is 16 bits wide. It stops at 65535 instead of wrapping.
- R7: A cycle with err_clr=1 sets err_count to 0. If a checked byte arrives in that same cycle, err_count becomes that byte's error count.
- R8: With pat_sel=1, each selected transmit timeslot sends the next byte of the tone. With e1_sel=0 the tone is 1E 0B 0B 1E 9E 8B 8B 9E (hex). With e1_sel=1 it is 34 21 21 34 B4 A1 A1 B4. Transmit and receive keep separate phases, each starting at the first byte after reset.
- R9: With pat_sel=1, a receive timeslot whose bit rx_test_en[ts_idx] is 1 has its byte replaced by the next tone byte. No errors are counted while pat_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_sel | input | 1 | 0: pseudo-random test, 1: milliwatt tone |
| e1_sel | input | 1 | 0: mu-law tone, 1: A-law tone |
| tx_test_en | input | NUM_TS | Per-timeslot transmit pattern enables |
| rx_test_en | input | NUM_TS | Per-timeslot receive check/replace enables |
| byte_stb | input | 1 | A timeslot byte is present this cycle |
| ts_idx | input | TS_W | Timeslot index of the present byte |
| tx_byte_in | input | 8 | Transmit byte before pattern insertion |
| rx_byte_in | input | 8 | Receive byte before checking or replacement |
| err_clr | input | 1 | Clears the error counter |
| tx_byte_out | output | 8 | Transmit byte after insertion |
| rx_byte_out | output | 8 | Receive byte after replacement |
| out_valid | output | 1 | Output bytes updated this cycle |
| err_count | output | CNT_W | Saturating bit-error count |

## Verification
Two functions can fall in the same cycle: a counter clear, and a checked receive byte that carries errors. The bench provokes this by locking the checker and then feeding all-ones bytes, each of which is worth exactly 8 errors, while it pulses err_clr in the strobe cycle. It judges the result by expecting err_count to read exactly 8, not 0 and not the old total plus 8. The same all-ones stream drives the counter into saturation. There the bench checks that further error bytes hold it at 65535, and that a clear issued together with an error byte still brings it down to 8.

// File: rtl/tst_pkg.sv
`timescale 1ns/1ps
package tst_pkg;
    localparam int BYTE_W    = 8;
    localparam int PRBS_W    = 15;
    localparam int SYNC_BITS = 15;
    localparam int MW_LEN    = 8;
    localparam int MW_PH_W   = $clog2(MW_LEN);

    typedef enum logic [1:0] {
        CHK_IDLE = 2'd0,
        CHK_FILL = 2'd1,
        CHK_LOCK = 2'd2
    } chk_state_t;

    // Milliwatt tone: the second half is the first half with the sign bit set.
    function automatic logic [BYTE_W-1:0] mw_byte(input logic alaw,
                                                   input logic [MW_PH_W-1:0] ph);
        logic [BYTE_W-1:0] b;
        unique case (ph[1:0])
            2'd0, 2'd3: b = alaw ? 8'h34 : 8'h1E;
            default:    b = alaw ? 8'h21 : 8'h0B;
        endcase
        if (ph[2]) b = b | 8'h80;
        return b;
    endfunction
endpackage

// File: rtl/tst_prbs_gen.sv
`timescale 1ns/1ps
module tst_prbs_gen #(
    parameter int PW    = 15,
    parameter int TAP_A = 14,
    parameter int TAP_B = 13,
    parameter int BW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [BW-1:0] pat_byte
);
    logic [PW-1:0] sreg;
    logic [PW-1:0] sreg_nx;

    always_comb begin
        logic [PW-1:0] s;
        logic          nb;
        s        = sreg;
        pat_byte = '0;
        for (int i = BW - 1; i >= 0; i--) begin
            nb          = s[TAP_A] ^ s[TAP_B];
            pat_byte[i] = nb;
            s           = {s[PW-2:0], nb};
        end
        sreg_nx = s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   sreg <= '1;
        else if (adv) sreg <= sreg_nx;
    end
endmodule

// File: rtl/tst_prbs_chk.sv
`timescale 1ns/1ps
module tst_prbs_chk
    import tst_pkg::*;
#(
    parameter int PW    = 15,
    parameter int TAP_A = 14,
    parameter int TAP_B = 13,
    parameter int BW    = 8,
    parameter int SYNC  = 15,
    localparam int EW   = $clog2(BW + 1),
    localparam int FW   = $clog2(SYNC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pat_sel,
    input  logic          chk_en,
    input  logic [BW-1:0] din,
    output logic [EW-1:0] err_n
);
    chk_state_t    state, state_nx;
    logic [PW-1:0] rreg, rreg_nx;
    logic [FW-1:0] fill, fill_nx;
    logic [FW-1:0] fill_eff;

    assign fill_eff = (state == CHK_IDLE) ? '0 : fill;

    // Bit-serial compare of one byte, MSB first.
    always_comb begin
        logic [PW-1:0] r;
        logic [FW-1:0] f;
        logic          exp_b;
        r     = rreg;
        f     = fill_eff;
        err_n = '0;
        for (int i = BW - 1; i >= 0; i--) begin
            exp_b = r[TAP_A] ^ r[TAP_B];
            if ((int'(f) >= SYNC) && (din[i] != exp_b)) err_n = err_n + 1'b1;
            r = {r[PW-2:0], din[i]};
            if (int'(f) < SYNC) f = f + 1'b1;
        end
        rreg_nx = r;
        fill_nx = f;
    end

    // Next-state process.
    always_comb begin
        state_nx = state;
        unique case (state)
            CHK_IDLE: if (!pat_sel) state_nx = CHK_FILL;
            CHK_FILL: begin
                if (pat_sel)                                     state_nx = CHK_IDLE;
                else if (chk_en && (int'(fill_nx) >= SYNC))      state_nx = CHK_LOCK;
            end
            CHK_LOCK: if (pat_sel) state_nx = CHK_IDLE;
            default:  state_nx = CHK_IDLE;
        endcase
    end

    // State register with its data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CHK_FILL;
            fill  <= '0;
            rreg  <= '1;
        end else begin
            state <= state_nx;
            if (state_nx == CHK_IDLE) fill <= '0;
            else if (chk_en) begin
                fill <= fill_nx;
                rreg <= rreg_nx;
            end else if (state == CHK_IDLE) fill <= '0;
        end
    end
endmodule

// File: rtl/tst_err_cnt.sv
`timescale 1ns/1ps
module tst_err_cnt #(
    parameter int CNT_W = 16,
    parameter int ADD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [ADD_W-1:0] add,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;

    always_comb begin
        base = clr ? '0 : count;
        sum  = {1'b0, base} + {{(CNT_W + 1 - ADD_W){1'b0}}, add};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else if (clr || add_en) begin
            if (add_en) count <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
            else        count <= '0;
        end
    end
endmodule

// File: rtl/ts_pattern_tester.sv
`timescale 1ns/1ps
module ts_pattern_tester
    import tst_pkg::*;
#(
    parameter int NUM_TS = 32,
    parameter int CNT_W  = 16,
    localparam int TS_W  = $clog2(NUM_TS),
    localparam int EW    = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pat_sel,
    input  logic              e1_sel,
    input  logic [NUM_TS-1:0] tx_test_en,
    input  logic [NUM_TS-1:0] rx_test_en,
    input  logic              byte_stb,
    input  logic [TS_W-1:0]   ts_idx,
    input  logic [BYTE_W-1:0] tx_byte_in,
    input  logic [BYTE_W-1:0] rx_byte_in,
    input  logic              err_clr,
    output logic [BYTE_W-1:0] tx_byte_out,
    output logic [BYTE_W-1:0] rx_byte_out,
    output logic              out_valid,
    output logic [CNT_W-1:0]  err_count
);
    logic               tx_sel, rx_sel;
    logic               gen_adv, chk_en, mw_tx_adv, mw_rx_adv;
    logic [BYTE_W-1:0]  prbs_byte;
    logic [EW-1:0]      err_n;
    logic [MW_PH_W-1:0] mw_tx_ph, mw_rx_ph;
    logic [BYTE_W-1:0]  tx_nx, rx_nx;

    assign tx_sel    = tx_test_en[ts_idx];
    assign rx_sel    = rx_test_en[ts_idx];
    assign gen_adv   = byte_stb && tx_sel && !pat_sel;
    assign chk_en    = byte_stb && rx_sel && !pat_sel;
    assign mw_tx_adv = byte_stb && tx_sel && pat_sel;
    assign mw_rx_adv = byte_stb && rx_sel && pat_sel;

    tst_prbs_gen #(.PW(PRBS_W), .TAP_A(14), .TAP_B(13), .BW(BYTE_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (gen_adv),
        .pat_byte (prbs_byte)
    );

    tst_prbs_chk #(.PW(PRBS_W), .TAP_A(14), .TAP_B(13), .BW(BYTE_W), .SYNC(SYNC_BITS)) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .pat_sel (pat_sel),
        .chk_en  (chk_en),
        .din     (rx_byte_in),
        .err_n   (err_n)
    );

    tst_err_cnt #(.CNT_W(CNT_W), .ADD_W(EW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (err_clr),
        .add_en (chk_en),
        .add    (err_n),
        .count  (err_count)
    );

    always_comb begin
        tx_nx = tx_byte_in;
        rx_nx = rx_byte_in;
        if (tx_sel) tx_nx = pat_sel ? mw_byte(e1_sel, mw_tx_ph) : prbs_byte;
        if (rx_sel && pat_sel) rx_nx = mw_byte(e1_sel, mw_rx_ph);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte_out <= '0;
            rx_byte_out <= '0;
            out_valid   <= 1'b0;
            mw_tx_ph    <= '0;
            mw_rx_ph    <= '0;
        end else begin
            out_valid <= byte_stb;
            if (byte_stb) begin
                tx_byte_out <= tx_nx;
                rx_byte_out <= rx_nx;
            end
            if (mw_tx_adv) mw_tx_ph <= mw_tx_ph + 1'b1;
            if (mw_rx_adv) mw_rx_ph <= mw_rx_ph + 1'b1;
        end
    end
endmodule

// File: rtl/ts_pattern_tester_sva.sv
`timescale 1ns/1ps
module ts_pattern_tester_sva #(
    parameter int NUM_TS = 32,
    parameter int CNT_W  = 16,
    localparam int TS_W  = $clog2(NUM_TS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pat_sel,
    input logic [NUM_TS-1:0] tx_test_en,
    input logic              byte_stb,
    input logic [TS_W-1:0]   ts_idx,
    input logic [7:0]        tx_byte_in,
    input logic [7:0]        rx_byte_in,
    input logic              err_clr,
    input logic [7:0]        tx_byte_out,
    input logic [7:0]        rx_byte_out,
    input logic              out_valid,
    input logic [CNT_W-1:0]  err_count
);
    assert_valid_follows_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> out_valid);
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> !out_valid);
    assert_tx_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !tx_test_en[ts_idx]) |=> (tx_byte_out == $past(tx_byte_in)));
    assert_rx_prbs_unchanged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !pat_sel) |=> (rx_byte_out == $past(rx_byte_in)));
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((&err_count) && !err_clr) |=> (&err_count));
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !byte_stb) |=> (err_count == '0));
    assert_tone_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel && !err_clr) |=> $stable(err_count));
    assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_count - $past(err_count)) <= CNT_W'(8)));
endmodule

bind ts_pattern_tester ts_pattern_tester_sva #(.NUM_TS(NUM_TS), .CNT_W(CNT_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .pat_sel     (pat_sel),
    .tx_test_en  (tx_test_en),
    .byte_stb    (byte_stb),
    .ts_idx      (ts_idx),
    .tx_byte_in  (tx_byte_in),
    .rx_byte_in  (rx_byte_in),
    .err_clr     (err_clr),
    .tx_byte_out (tx_byte_out),
    .rx_byte_out (rx_byte_out),
    .out_valid   (out_valid),
    .err_count   (err_count)
);

// File: tb/ts_pattern_tester_tb.sv
`timescale 1ns/1ps
module ts_pattern_tester_tb;
    localparam int NUM_TS = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pat_sel = 1'b0, e1_sel = 1'b0;
    logic [NUM_TS-1:0] tx_test_en = '0, rx_test_en = '0;
    logic              byte_stb = 1'b0;
    logic [4:0]        ts_idx = '0;
    logic [7:0]        tx_byte_in = '0, rx_byte_in = '0;
    logic              err_clr = 1'b0;
    logic [7:0]        tx_byte_out, rx_byte_out;
    logic              out_valid;
    logic [CNT_W-1:0]  err_count;

    int vectors = 0, miscompares = 0;
    logic [14:0] tx_gs;
    logic [14:0] rx_gs;
    logic [2:0]  tph, rph;

    always #2.5 clk = ~clk;

    ts_pattern_tester #(.NUM_TS(NUM_TS), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .e1_sel(e1_sel),
        .tx_test_en(tx_test_en), .rx_test_en(rx_test_en), .byte_stb(byte_stb),
        .ts_idx(ts_idx), .tx_byte_in(tx_byte_in), .rx_byte_in(rx_byte_in),
        .err_clr(err_clr), .tx_byte_out(tx_byte_out), .rx_byte_out(rx_byte_out),
        .out_valid(out_valid), .err_count(err_count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic prbs_next(inout logic [14:0] s, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            b[i] = s[14] ^ s[13];
            s    = {s[13:0], b[i]};
        end
    endtask

    function automatic logic [7:0] tone(input logic alaw, input logic [2:0] ph);
        logic [7:0] hi, lo;
        hi = alaw ? 8'h34 : 8'h1E;
        lo = alaw ? 8'h21 : 8'h0B;
        return (((ph[1:0] == 2'd0) || (ph[1:0] == 2'd3)) ? hi : lo) | (ph[2] ? 8'h80 : 8'h00);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        byte_stb = 1'b0;
        err_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tx_gs = '1;
        tph = '0;
        rph = '0;
    endtask

    // One byte through the block; outputs are compared after the next edge.
    task automatic put(input int ts, input logic [7:0] txb, input logic [7:0] rxb, input logic clr);
        logic [7:0] etx, erx;
        string ttag, rtag;
        etx = txb; erx = rxb; ttag = "R2 tx pass"; rtag = "R2 rx pass";
        if (tx_test_en[ts]) begin
            if (pat_sel) begin etx = tone(e1_sel, tph); tph++; ttag = "R8 tx tone"; end
            else begin prbs_next(tx_gs, etx); ttag = "R3 tx prbs"; end
        end
        if (rx_test_en[ts]) begin
            if (pat_sel) begin erx = tone(e1_sel, rph); rph++; rtag = "R9 rx tone"; end
            else rtag = "R5 rx prbs unchanged";
        end
        @(negedge clk);
        ts_idx = 5'(ts); tx_byte_in = txb; rx_byte_in = rxb; byte_stb = 1'b1; err_clr = clr;
        @(negedge clk);
        byte_stb = 1'b0; err_clr = 1'b0;
        check(out_valid == 1'b1, "R2 valid", int'(out_valid), 1);
        check(tx_byte_out == etx, ttag, int'(tx_byte_out), int'(etx));
        check(rx_byte_out == erx, rtag, int'(rx_byte_out), int'(erx));
    endtask

    task automatic clear_only();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(err_count == 0, "R7 clear", int'(err_count), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] b;
        bit         flipped;
        do_reset();
        // R1 reset state
        check(tx_byte_out == 0, "R1 tx reset", int'(tx_byte_out), 0);
        check(rx_byte_out == 0, "R1 rx reset", int'(rx_byte_out), 0);
        check(out_valid == 0, "R1 valid reset", int'(out_valid), 0);
        check(err_count == 0, "R1 count reset", int'(err_count), 0);

        // R3 R4 R5: pseudo-random sweep, checker fed a stream from another seed
        pat_sel = 1'b0;
        tx_test_en = 32'h8421_1209;
        rx_test_en = 32'h0101_0110;
        rx_gs = 15'h5A5A;
        for (int f = 0; f < 4; f++)
            for (int t = 0; t < NUM_TS; t++) begin
                if (rx_test_en[t]) prbs_next(rx_gs, b); else b = 8'(t) ^ 8'h3C;
                put(t, 8'(t * 7 + f), b, 1'b0);
            end
        check(err_count == 0, "R4 synced stream no errors", int'(err_count), 0);

        // R4 single flipped bit gives exactly three errors
        flipped = 0;
        for (int f = 0; f < 3; f++)
            for (int t = 0; t < NUM_TS; t++) begin
                if (rx_test_en[t]) begin
                    prbs_next(rx_gs, b);
                    if (!flipped) begin b[4] = ~b[4]; flipped = 1; end
                end else b = 8'hC3;
                put(t, 8'h55, b, 1'b0);
            end
        check(err_count == 3, "R4 one flip three errors", int'(err_count), 3);
        clear_only();

        // R8 R9: mu-law then A-law tone
        do_reset();
        pat_sel = 1'b1;
        tx_test_en = 32'hF000_000F;
        rx_test_en = 32'h0003_0C00;
        for (int e = 0; e < 2; e++) begin
            e1_sel = e[0];
            for (int f = 0; f < 3; f++)
                for (int t = 0; t < NUM_TS; t++) put(t, 8'(t), 8'hFF, 1'b0);
        end
        check(err_count == 0, "R9 tone mode no counting", int'(err_count), 0);

        // R4 R6 R7: all-ones stream into a fresh checker
        do_reset();
        pat_sel = 1'b0;
        tx_test_en = '0;
        rx_test_en = 32'h0000_0020;
        put(5, 8'h00, 8'hFF, 1'b0);
        check(err_count == 0, "R4 fill byte1", int'(err_count), 0);
        put(5, 8'h00, 8'hFF, 1'b0);
        check(err_count == 1, "R4 fill byte2", int'(err_count), 1);
        put(5, 8'h00, 8'hFF, 1'b0);
        check(err_count == 9, "R4 locked byte3", int'(err_count), 9);
        put(6, 8'h00, 8'hFF, 1'b0);
        check(err_count == 9, "R2 unselected rx not checked", int'(err_count), 9);
        for (int k = 0; k < 8200; k++) put(5, 8'h00, 8'hFF, 1'b0);
        check(err_count == 16'hFFFF, "R6 saturate", int'(err_count), 16'hFFFF);
        put(5, 8'h00, 8'hFF, 1'b0);
        check(err_count == 16'hFFFF, "R6 hold at max", int'(err_count), 16'hFFFF);
        put(5, 8'h00, 8'hFF, 1'b1);
        check(err_count == 8, "R7 clear with error byte", int'(err_count), 8);
        clear_only();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule